// File: doc/BRIEF.md
# Three-Segment Base-Limit Address Translator

This block turns a 16-bit logical address into a 21-bit physical address for a processor that uses segmented memory. Each mapping context splits the logical space into three segments. A segment has a limit, which is the first logical address that lies beyond it, and a base, which gives its start in physical memory in 32-byte units. The three contexts are privileged (kernel) code, unprivileged (user) code, and the long-distance load/store instruction forms. Each context has its own full set of three base/limit pairs, so the block holds nine pairs in all.

The processor reports its privilege level and whether the current access is a long-distance one. The block uses these to pick a bank. It compares the address against that bank's limits in ascending order and adds the chosen base, shifted left by five bits, to the address. The result is registered, so it appears one cycle after the request. An address that lies past the third limit produces a mapping-fault pulse instead of an address. Software loads the nine pairs through a simple write port.

Top module: `segmmu_top`

## Requirements
- R1: After reset, all outputs are 0 and all limits are 0, so every translation request faults.
- R2: When `far_ctx` is 1, the long-distance bank (bank 2) is used whatever `kern` holds. When `far_ctx` is 0, `kern`=1 selects the kernel bank (bank 0) and `kern`=0 selects the user bank (bank 1).
- R3: The segment is chosen in ascending order. `la` < limit1 gives segment 1. Otherwise `la` < limit2 gives segment 2. Otherwise `la` < limit3 gives segment 3. An address equal to a limit falls through to the next segment, and a segment whose limit equals the previous limit is never chosen. A valid result reports 1, 2 or 3 on `seg_idx`.
- R4: On a valid result, `pa` = (base × 32 + `la`) mod 2^21, where base is the base of the chosen segment.
- R5: If `la` ≥ limit3, `fault` is 1 for exactly the cycle that answers that request, and `pa_valid`, `pa` and `seg_idx` are 0 in that cycle.
- R6: A request in the cycle ending at clock edge k is answered in the cycle that begins at edge k. A cycle with `req_valid` = 0 is answered with `pa_valid` = 0 and `fault` = 0.
- R7: A write with `wr_en` = 1 stores `wr_data` into the register selected by three fields. `wr_bank` picks the bank: 0 kernel, 1 user, 2 long-distance. `wr_seg` picks the segment: 0, 1 or 2 for segments 1 to 3. `wr_base` picks the register: 1 for base, 0 for limit. The new value applies to requests in later cycles. A request in the same cycle as the write still sees the old value.
- R8: A write with `wr_bank` = 3 or `wr_seg` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank of the write (0 kernel, 1 user, 2 long-distance) |
| wr_seg | input | 2 | Segment of the write (0..2) |
| wr_base | input | 1 | 1 writes the base, 0 writes the limit |
| wr_data | input | 16 | Value written |
| kern | input | 1 | Processor is in privileged mode |
| far_ctx | input | 1 | Access comes from a long-distance load/store |
| req_valid | input | 1 | Translation request strobe |
| la | input | 16 | Logical address |
| pa_valid | output | 1 | Registered physical address is valid |
| pa | output | 21 | Physical address |
| seg_idx | output | 2 | Segment used (1..3), 0 when no valid result |
| fault | output | 1 | Mapping fault for the answered request |

## Verification
A register write and a translation request can land in the same cycle, and the write may target the very limit that decides the request. The bench provokes this by rewriting the kernel first limit from 0x1000 to 0x2000 while it requests address 0x1800 in the kernel bank. It expects the old mapping (segment 2) in the answer to that cycle. It then repeats the request one cycle later and expects segment 1 with the first base.

// File: rtl/segmmu_pkg.sv
package segmmu_pkg;

  typedef enum logic [1:0] {
    BANK_KERN = 2'd0,
    BANK_USER = 2'd1,
    BANK_FAR  = 2'd2
  } bank_e;

  // Bank chosen by the CPU context: long-distance context wins over privilege
  function automatic bank_e pick_bank(input logic kern, input logic far_ctx);
    if (far_ctx)   return BANK_FAR;
    else if (kern) return BANK_KERN;
    else           return BANK_USER;
  endfunction

endpackage

// File: rtl/segmmu_regfile.sv
module segmmu_regfile #(
  parameter int LA_W   = 16,
  parameter int BASE_W = 16,
  parameter int NSEG   = 3,
  parameter int NBANK  = 3,
  localparam int BSEL_W = 2,
  localparam int SSEL_W = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [BSEL_W-1:0]                 wr_bank,
  input  logic [SSEL_W-1:0]                 wr_seg,
  input  logic                              wr_base,
  input  logic [LA_W-1:0]                   wr_data,
  input  logic [BSEL_W-1:0]                 rd_bank,
  output logic [NSEG-1:0][LA_W-1:0]         lim_o,
  output logic [NSEG-1:0][BASE_W-1:0]       base_o
);

  logic [NBANK-1:0][NSEG-1:0][LA_W-1:0]   lim_q;
  logic [NBANK-1:0][NSEG-1:0][BASE_W-1:0] base_q;
  logic [NBANK-1:0][NSEG-1:0]             hit_lim;
  logic [NBANK-1:0][NSEG-1:0]             hit_base;
  logic                                   wr_out_of_range;

  // Per-register write decode
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      assign hit_lim[b][s]  = wr_en && !wr_base && (wr_bank == BSEL_W'(b)) && (wr_seg == SSEL_W'(s));
      assign hit_base[b][s] = wr_en &&  wr_base && (wr_bank == BSEL_W'(b)) && (wr_seg == SSEL_W'(s));
    end
  end

  assign wr_out_of_range = wr_en && ((int'(wr_bank) >= NBANK) || (int'(wr_seg) >= NSEG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      base_q <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        for (int s = 0; s < NSEG; s++) begin
          if (hit_lim[b][s])  lim_q[b][s]  <= wr_data;
          if (hit_base[b][s]) base_q[b][s] <= BASE_W'(wr_data);
        end
      end
    end
  end

  always_comb begin
    lim_o  = '0;
    base_o = '0;
    if (int'(rd_bank) < NBANK) begin
      lim_o  = lim_q[rd_bank];
      base_o = base_q[rd_bank];
    end
  end

  AST_BAD_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_of_range |=> ($stable(lim_q) && $stable(base_q))); // R8

  AST_ONE_REG_PER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_lim, hit_base}) <= 1); // R7

endmodule

// File: rtl/segmmu_segsel.sv
module segmmu_segsel #(
  parameter int LA_W = 16,
  parameter int NSEG = 3,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic [LA_W-1:0]           la,
  input  logic [NSEG-1:0][LA_W-1:0] lim,
  output logic                      hit,
  output logic [SEL_W-1:0]          sel
);

  logic [NSEG-1:0] below;

  // One comparator per segment
  for (genvar i = 0; i < NSEG; i++) begin : g_cmp
    assign below[i] = la < lim[i];
  end

  // Lowest segment whose limit lies above the address wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (below[i]) begin
        hit = 1'b1;
        sel = SEL_W'(i);
      end
    end
  end

endmodule

// File: rtl/segmmu_top.sv
module segmmu_top #(
  parameter int LA_W   = 16,
  parameter int BASE_W = 16,
  parameter int SHIFT  = 5,
  parameter int NSEG   = 3,
  parameter int NBANK  = 3,
  localparam int PA_W  = BASE_W + SHIFT,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int IDX_W = $clog2(NSEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_bank,
  input  logic [1:0]        wr_seg,
  input  logic              wr_base,
  input  logic [LA_W-1:0]   wr_data,
  input  logic              kern,
  input  logic              far_ctx,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   la,
  output logic              pa_valid,
  output logic [PA_W-1:0]   pa,
  output logic [IDX_W-1:0]  seg_idx,
  output logic              fault
);
  import segmmu_pkg::*;

  function automatic logic [PA_W-1:0] phys_sum(input logic [BASE_W-1:0] b,
                                               input logic [LA_W-1:0]   a);
    return {b, {SHIFT{1'b0}}} + PA_W'(a);
  endfunction

  bank_e                       cur_bank;
  logic [1:0]                  rd_bank;
  logic [NSEG-1:0][LA_W-1:0]   sel_lim;
  logic [NSEG-1:0][BASE_W-1:0] sel_base;
  logic                        seg_hit;
  logic [SEL_W-1:0]            seg_sel;
  logic [BASE_W-1:0]           base_pick;
  logic [PA_W-1:0]             pa_next;

  assign cur_bank = pick_bank(kern, far_ctx);
  assign rd_bank  = cur_bank;

  segmmu_regfile #(
    .LA_W(LA_W), .BASE_W(BASE_W), .NSEG(NSEG), .NBANK(NBANK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_seg(wr_seg),
    .wr_base(wr_base), .wr_data(wr_data),
    .rd_bank(rd_bank), .lim_o(sel_lim), .base_o(sel_base)
  );

  segmmu_segsel #(.LA_W(LA_W), .NSEG(NSEG)) u_sel (
    .la(la), .lim(sel_lim), .hit(seg_hit), .sel(seg_sel)
  );

  assign base_pick = sel_base[seg_sel];
  assign pa_next   = phys_sum(base_pick, la);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_valid <= 1'b0;
      pa       <= '0;
      seg_idx  <= '0;
      fault    <= 1'b0;
    end else if (req_valid && seg_hit) begin
      pa_valid <= 1'b1;
      pa       <= pa_next;
      seg_idx  <= IDX_W'(seg_sel) + IDX_W'(1);
      fault    <= 1'b0;
    end else begin
      pa_valid <= 1'b0;
      pa       <= '0;
      seg_idx  <= '0;
      fault    <= req_valid;
    end
  end

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && pa_valid)); // R5

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (seg_idx == '0 && pa == '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!pa_valid && !fault)); // R6

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (pa_valid || fault)); // R6

  AST_SEG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |-> (seg_idx != '0 && int'(seg_idx) <= NSEG)); // R3

  AST_FIRST_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && la < sel_lim[0]) |=> (pa_valid && seg_idx == IDX_W'(1))); // R3

  AST_FAR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    far_ctx |-> rd_bank == 2'd2); // R2

endmodule

// File: tb/segmmu_top_test.sv
module segmmu_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_bank = '0;
  logic [1:0]  wr_seg = '0;
  logic        wr_base = 1'b0;
  logic [15:0] wr_data = '0;
  logic        kern = 1'b0;
  logic        far_ctx = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] la = '0;
  logic        pa_valid;
  logic [20:0] pa;
  logic [1:0]  seg_idx;
  logic        fault;

  int n_tests = 0;
  int n_fail = 0;
  int sh_lim [3][3];
  int sh_base[3][3];

  segmmu_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_seg(wr_seg),
    .wr_base(wr_base), .wr_data(wr_data), .kern(kern), .far_ctx(far_ctx),
    .req_valid(req_valid), .la(la), .pa_valid(pa_valid), .pa(pa),
    .seg_idx(seg_idx), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {kern, far_ctx, la, expected segment (0 = fault)}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'h0000, 2'd1},
    {1'b1, 1'b0, 16'h0FFF, 2'd1},
    {1'b1, 1'b0, 16'h1000, 2'd2},
    {1'b1, 1'b0, 16'h7FFF, 2'd3},
    {1'b1, 1'b0, 16'h8000, 2'd0},
    {1'b0, 1'b0, 16'h07FF, 2'd1},
    {1'b0, 1'b0, 16'h0800, 2'd2},
    {1'b0, 1'b0, 16'h0C00, 2'd3},
    {1'b0, 1'b0, 16'hF000, 2'd0},
    {1'b1, 1'b1, 16'h1FFF, 2'd1},
    {1'b0, 1'b1, 16'h2000, 2'd3},
    {1'b1, 1'b1, 16'h3000, 2'd0},
    {1'b0, 1'b1, 16'h0500, 2'd1},
    {1'b1, 1'b0, 16'hFFFF, 2'd0}
  };

  task automatic check(input string rq, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", rq, got, exp);
    end
  endtask

  function automatic int bank_of(input logic k, input logic f);
    return f ? 2 : (k ? 0 : 1);
  endfunction

  function automatic int exp_pa(input int bank, input int seg, input int addr);
    return (sh_base[bank][seg-1] * 32 + addr) % 2097152;
  endfunction

  task automatic wr(input int bank, input int seg, input bit isbase, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'(bank); wr_seg = 2'(seg); wr_base = isbase; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (bank < 3 && seg < 3) begin
      if (isbase) sh_base[bank][seg] = data; else sh_lim[bank][seg] = data;
    end
  endtask

  // Issue one request and sample the registered answer one cycle later
  task automatic req(input logic k, input logic f, input logic [15:0] a);
    @(negedge clk);
    kern = k; far_ctx = f; la = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_seg(input string rq, input logic k, input logic f,
                           input logic [15:0] a, input int exp_seg);
    req(k, f, a);
    check(rq, int'(seg_idx), exp_seg);
    if (exp_seg == 0) begin
      check(rq, int'(fault), 1);
      check(rq, int'(pa), 0);
    end else begin
      check(rq, int'(pa_valid), 1);
      check(rq, int'(pa), exp_pa(bank_of(k, f), exp_seg, int'(a)));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 3; s++) begin sh_lim[b][s] = 0; sh_base[b][s] = 0; end

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pa_valid", int'(pa_valid), 0);
    check("R1 fault", int'(fault), 0);
    check("R1 seg_idx", int'(seg_idx), 0);
    rst_n = 1'b1;
    check_seg("R1 zero limits fault", 1'b1, 1'b0, 16'h0000, 0);

    // R7: load all three banks
    wr(0, 0, 0, 'h1000); wr(0, 1, 0, 'h4000); wr(0, 2, 0, 'h8000);
    wr(0, 0, 1, 'h0100); wr(0, 1, 1, 'h0200); wr(0, 2, 1, 'h0300);
    wr(1, 0, 0, 'h0800); wr(1, 1, 0, 'h0C00); wr(1, 2, 0, 'hF000);
    wr(1, 0, 1, 'h1000); wr(1, 1, 1, 'h2000); wr(1, 2, 1, 'hFFFF);
    wr(2, 0, 0, 'h2000); wr(2, 1, 0, 'h2000); wr(2, 2, 0, 'h3000);
    wr(2, 0, 1, 'h0040); wr(2, 1, 1, 'h0050); wr(2, 2, 1, 'h0060);

    // R2 R3 R4 R5: table walk (bank choice, ascending compare, sum with wrap, fault)
    for (int i = 0; i < NVEC; i++) begin
      check_seg($sformatf("R3/R4/R2/R5 vec%0d", i), VEC[i][19], VEC[i][18],
                VEC[i][17:2], int'(VEC[i][1:0]));
    end

    // R6: idle cycle answered quietly
    @(negedge clk);
    check("R6 idle pa_valid", int'(pa_valid), 0);
    check("R6 idle fault", int'(fault), 0);

    // R5: fault lasts only for its own answer
    req(1'b1, 1'b0, 16'h9000);
    check("R5 fault set", int'(fault), 1);
    @(negedge clk);
    check("R5 fault one cycle", int'(fault), 0);

    // R7: write and request in the same cycle see the old limit
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'd0; wr_seg = 2'd0; wr_base = 1'b0; wr_data = 16'h2000;
    kern = 1'b1; far_ctx = 1'b0; la = 16'h1800; req_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 same cycle old seg", int'(seg_idx), 2);
    check("R7 same cycle old pa", int'(pa), exp_pa(0, 2, 'h1800));
    sh_lim[0][0] = 'h2000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 next cycle new seg", int'(seg_idx), 1);
    check("R7 next cycle new pa", int'(pa), exp_pa(0, 1, 'h1800));

    // R8: out-of-range writes change nothing
    wr(3, 0, 0, 'h0000);
    wr(3, 1, 1, 'h7777);
    wr(0, 3, 0, 'h0000);
    wr(1, 3, 1, 'h5555);
    check_seg("R8 kernel seg1 kept", 1'b1, 1'b0, 16'h0010, 1);
    check_seg("R8 kernel seg3 kept", 1'b1, 1'b0, 16'h7000, 3);
    check_seg("R8 user seg2 kept", 1'b0, 1'b0, 16'h0900, 2);
    check_seg("R8 user seg3 kept", 1'b0, 1'b0, 16'h1000, 3);
    check_seg("R8 far seg1 kept", 1'b0, 1'b1, 16'h0010, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule